// File: doc/BRIEF.md
# Multichannel DAC Command Decoder

This block is the digital control core of a 32-channel, 14-bit voltage-output converter. It takes command words that an upstream front end has already deserialized. Each word is 21 bits and arrives with a one-cycle valid strobe. For every channel the block holds three registers: a data register, a gain register and an offset register. It also holds a programmable clear code, a soft power-down flag and an active-low busy output.

A non-zero register-select prefix writes one register of one channel. When the prefix is zero, the 5-bit address field selects a special function instead: no-op, clear-code write, soft clear, soft power-down, soft power-up or soft reset. A synchronized active-low clear pin does the same bulk load as the soft clear. A power-down pin is ORed with the soft flag. A combinational read port, indexed by register file and channel, makes every stored value observable.

Top module: `dac_cmd_core`

## Requirements
- R1: The command word is {sel[20:19], addr[18:14], data[13:0]}. An accepted command with sel=11 writes data into the data register of channel addr, sel=01 writes it into the gain register and sel=10 writes it into the offset register. The read port returns the clear code for rd_sel=00, gain for 01, offset for 10 and channel data for 11, and it leaves all other entries unchanged.
- R2: With sel=00, address 00000 (no-op) and every address not listed in R3, R4, R6 and R8 change no register, whatever the data field holds.
- R3: With sel=00, address 00001 loads data into the clear-code register. The clear-code register is zero after reset.
- R4: With sel=00, address 00010 copies the clear code into the data register of every channel and ignores the data field. busy_n then stays low for exactly CLR_CYC cycles.
- R5: A falling edge on clr_n_pin, after a two-stage synchronizer, does the same bulk load and busy pulse as R4. It loads once per assertion, however long the pin stays low.
- R6: Address 01000 sets the soft power-down flag and address 01001 clears it. pd_active is the OR of pd_pin and that flag, so a soft power-up cannot override the pin.
- R7: While pd_active is high, channel writes, clear-code writes, soft clears and pin clears are rejected, no busy pulse occurs, and all stored values are kept.
- R8: Address 01111 is a soft reset and is accepted even while powered down. It sets every data register and offset register to 0, every gain register to 3FFF (full scale) and the clear code to 0, clears the soft power-down flag, and holds busy_n low for RST_CYC cycles.
- R9: Any command whose valid strobe arrives while busy_n is low is ignored.
- R10: After rst_n, busy_n is 1, pd_active equals pd_pin, and all registers hold the R8 defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe qualifying cmd_word |
| cmd_word | input | 21 | Command: select, address, data |
| clr_n_pin | input | 1 | Asynchronous active-low clear request |
| pd_pin | input | 1 | Hardware power-down request |
| rd_sel | input | 2 | Read register file select |
| rd_ch | input | 5 | Read channel index |
| rd_data | output | 14 | Selected register contents |
| busy_n | output | 1 | Low while a bulk clear or soft reset runs |
| pd_active | output | 1 | Effective power-down state |

## Verification
The assertions assume that cmd_valid is only a single-cycle pulse and that pd_pin changes synchronously to clk. Without the second assumption, the power-up property cannot rely on the pin being low in the cycle after the command. The bench drives every input at the falling clock edge and keeps pd_pin steady across each power-up command. It changes clr_n_pin only while the block is idle and holds it long enough for the synchronizer to see each level. It also sends commands during a busy window on purpose, so that R9 is exercised rather than assumed.

// File: rtl/dac_cmd_core.sv
module dac_cmd_core #(
  parameter int NCH     = 32,
  parameter int DW      = 14,
  parameter int AW      = 5,
  parameter int CLR_CYC = 1750,
  parameter int RST_CYC = 6750
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [AW+DW+1:0]  cmd_word,
  input  logic              clr_n_pin,
  input  logic              pd_pin,
  input  logic [1:0]        rd_sel,
  input  logic [AW-1:0]     rd_ch,
  output logic [DW-1:0]     rd_data,
  output logic              busy_n,
  output logic              pd_active
);

  localparam int MAXC = (CLR_CYC > RST_CYC) ? CLR_CYC : RST_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [AW-1:0] OP_CCW  = AW'(1);
  localparam logic [AW-1:0] OP_SCLR = AW'(2);
  localparam logic [AW-1:0] OP_PD   = AW'(8);
  localparam logic [AW-1:0] OP_PU   = AW'(9);
  localparam logic [AW-1:0] OP_RST  = AW'(15);
  localparam logic [DW-1:0] FULL    = '1;

  logic [DW-1:0] dat_q [NCH];
  logic [DW-1:0] gain_q [NCH];
  logic [DW-1:0] offs_q [NCH];
  logic [DW-1:0] clr_code;
  logic          soft_pd;
  logic [CW-1:0] busy_cnt;
  logic [2:0]    clr_sync;

  wire [1:0]    sel  = cmd_word[AW+DW+1 -: 2];
  wire [AW-1:0] addr = cmd_word[DW +: AW];
  wire [DW-1:0] dat  = cmd_word[DW-1:0];

  wire idle     = (busy_cnt == '0);
  wire wr_ok    = ~pd_active;
  wire clr_fall = clr_sync[2] & ~clr_sync[1];
  wire pin_clr  = clr_fall & idle & wr_ok;
  wire acc      = cmd_valid & idle & ~pin_clr;
  wire sfr      = acc & (sel == 2'b00);
  wire op_ccw   = sfr & (addr == OP_CCW) & wr_ok;
  wire op_sclr  = sfr & (addr == OP_SCLR) & wr_ok;
  wire op_pd    = sfr & (addr == OP_PD);
  wire op_pu    = sfr & (addr == OP_PU);
  wire op_rst   = sfr & (addr == OP_RST);
  wire ch_ok    = (int'(addr) < NCH);
  wire ch_wr    = acc & (sel != 2'b00) & wr_ok & ch_ok;
  wire bulk_clr = op_sclr | pin_clr;

  assign pd_active = pd_pin | soft_pd;
  assign busy_n    = idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_sync <= '1;
    else        clr_sync <= {clr_sync[1:0], clr_n_pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        busy_cnt <= '0;
    else if (op_rst)   busy_cnt <= CW'(RST_CYC);
    else if (bulk_clr) busy_cnt <= CW'(CLR_CYC);
    else if (!idle)    busy_cnt <= busy_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_code <= '0;
      soft_pd  <= 1'b0;
    end else if (op_rst) begin
      clr_code <= '0;
      soft_pd  <= 1'b0;
    end else begin
      if (op_ccw) clr_code <= dat;
      if (op_pd)  soft_pd  <= 1'b1;
      else if (op_pu) soft_pd <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        dat_q[i]  <= '0;
        gain_q[i] <= FULL;
        offs_q[i] <= '0;
      end
    end else if (op_rst) begin
      for (int i = 0; i < NCH; i++) begin
        dat_q[i]  <= '0;
        gain_q[i] <= FULL;
        offs_q[i] <= '0;
      end
    end else if (bulk_clr) begin
      for (int i = 0; i < NCH; i++) dat_q[i] <= clr_code;
    end else if (ch_wr) begin
      case (sel)
        2'b11:   dat_q[addr]  <= dat;
        2'b01:   gain_q[addr] <= dat;
        default: offs_q[addr] <= dat;
      endcase
    end
  end

  wire rd_ok = (int'(rd_ch) < NCH);

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      2'b00: rd_data = clr_code;
      2'b01: if (rd_ok) rd_data = gain_q[rd_ch];
      2'b10: if (rd_ok) rd_data = offs_q[rd_ch];
      default: if (rd_ok) rd_data = dat_q[rd_ch];
    endcase
  end

  p_ccw_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy_n && !pd_active && sel == 2'b00 && addr == OP_CCW && clr_sync[2:1] != 2'b10)
      |=> clr_code == $past(dat));

  p_sclr_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy_n && !pd_active && sel == 2'b00 && addr == OP_SCLR) |=> !busy_n);

  p_pd_enter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sel == 2'b00 && addr == OP_PD) |=> pd_active);

  p_pu_leave_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_pu) && !pd_pin) |-> !pd_active);

  p_pd_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_active && cmd_valid && sel == 2'b00 && addr == OP_CCW) |=> $stable(clr_code));

  p_pd_nobusy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_active && busy_n && !(cmd_valid && sel == 2'b00 && addr == OP_RST)) |=> busy_n);

  p_rst_dflt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_rst |=> (clr_code == '0 && !soft_pd && !busy_n));

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |=> ($stable(clr_code) && $stable(soft_pd)));

endmodule

// File: tb/test_dac_cmd_core.sv
module test_dac_cmd_core;
  localparam int CLR_CYC = 20;
  localparam int RST_CYC = 40;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, clr_n_pin = 1'b1, pd_pin = 1'b0;
  logic [20:0] cmd_word = '0;
  logic [1:0]  rd_sel = '0;
  logic [4:0]  rd_ch = '0;
  logic [13:0] rd_data;
  logic busy_n, pd_active;

  int n_chk = 0, n_fail = 0;

  typedef struct { logic [1:0] sel; int ch; logic [13:0] val; string tag; } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  dac_cmd_core #(.CLR_CYC(CLR_CYC), .RST_CYC(RST_CYC)) i_dac_cmd_core (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .clr_n_pin(clr_n_pin), .pd_pin(pd_pin), .rd_sel(rd_sel), .rd_ch(rd_ch),
    .rd_data(rd_data), .busy_n(busy_n), .pd_active(pd_active));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] sel, input logic [4:0] addr, input logic [13:0] d);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = {sel, addr, d};
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic expect_rd(input logic [1:0] sel, input int ch, input logic [13:0] v, input string tag);
    item_t it;
    it.sel = sel; it.ch = ch; it.val = v; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_idle();
    while (!busy_n) @(negedge clk);
  endtask

  function automatic int busy_len_from_now();
    return 0;
  endfunction

  task automatic count_busy(output int n);
    n = 0;
    while (!busy_n) begin
      n++;
      @(negedge clk);
    end
  endtask

  always begin
    @(negedge clk);
    if (sb_q.size() != 0) begin
      item_t it;
      it = sb_q.pop_front();
      rd_sel = it.sel;
      rd_ch  = 5'(it.ch);
      #5;
      check(it.tag, int'(rd_data), int'(it.val));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    int n;
    bit saw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 busy_n", busy_n, 1);
    check("R10 pd_active", pd_active, 0);
    expect_rd(2'b11, 0, 14'h0, "R10 data0");
    expect_rd(2'b01, 5, 14'h3FFF, "R10 gain5");
    expect_rd(2'b10, 7, 14'h0, "R10 offs7");
    expect_rd(2'b00, 0, 14'h0, "R10 clrcode");
    drain();

    // R1 channel writes
    send(2'b11, 5'd0, 14'h1234);
    send(2'b11, 5'd31, 14'h0ABC);
    send(2'b01, 5'd3, 14'h2000);
    send(2'b10, 5'd3, 14'h0011);
    expect_rd(2'b11, 0, 14'h1234, "R1 data0");
    expect_rd(2'b11, 31, 14'h0ABC, "R1 data31");
    expect_rd(2'b01, 3, 14'h2000, "R1 gain3");
    expect_rd(2'b10, 3, 14'h0011, "R1 offs3");
    expect_rd(2'b11, 1, 14'h0, "R1 data1 untouched");
    drain();

    // R2 no-op and unused address
    send(2'b00, 5'd0, 14'h3FFF);
    send(2'b00, 5'd5, 14'h3FFF);
    check("R2 busy_n", busy_n, 1);
    expect_rd(2'b00, 0, 14'h0, "R2 clrcode");
    expect_rd(2'b11, 0, 14'h1234, "R2 data0");
    drain();

    // R3 clear-code write
    send(2'b00, 5'd1, 14'h1555);
    expect_rd(2'b00, 0, 14'h1555, "R3 clrcode");
    expect_rd(2'b11, 0, 14'h1234, "R3 data0 kept");
    drain();

    // R4 soft clear
    send(2'b00, 5'd2, 14'h0F0F);
    count_busy(n);
    check("R4 busy length", n, CLR_CYC);
    expect_rd(2'b11, 0, 14'h1555, "R4 data0");
    expect_rd(2'b11, 17, 14'h1555, "R4 data17");
    expect_rd(2'b11, 31, 14'h1555, "R4 data31");
    expect_rd(2'b00, 0, 14'h1555, "R4 clrcode kept");
    expect_rd(2'b01, 3, 14'h2000, "R4 gain kept");
    drain();

    // R9 commands while busy are ignored
    send(2'b00, 5'd1, 14'h2AAA);
    send(2'b00, 5'd2, 14'h0);
    send(2'b11, 5'd2, 14'h0001);
    send(2'b00, 5'd1, 14'h0777);
    send(2'b00, 5'd8, 14'h0);
    check("R9 pd ignored", pd_active, 0);
    wait_idle();
    expect_rd(2'b11, 2, 14'h2AAA, "R9 data2");
    expect_rd(2'b00, 0, 14'h2AAA, "R9 clrcode");
    drain();

    // R5 clear pin
    send(2'b00, 5'd1, 14'h0321);
    send(2'b11, 5'd4, 14'h0100);
    @(negedge clk);
    clr_n_pin = 1'b0;
    saw = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (!busy_n) saw = 1'b1;
    end
    check("R5 busy seen", saw, 1);
    wait_idle();
    expect_rd(2'b11, 4, 14'h0321, "R5 data4");
    expect_rd(2'b11, 30, 14'h0321, "R5 data30");
    drain();
    send(2'b11, 5'd4, 14'h0200);
    repeat (10) @(negedge clk);
    check("R5 single load busy", busy_n, 1);
    expect_rd(2'b11, 4, 14'h0200, "R5 one load per assertion");
    drain();
    clr_n_pin = 1'b1;
    repeat (4) @(negedge clk);

    // R6 / R7 power-down
    send(2'b00, 5'd8, 14'h0);
    check("R6 soft pd", pd_active, 1);
    send(2'b11, 5'd0, 14'h0AAA);
    send(2'b00, 5'd1, 14'h0BBB);
    send(2'b00, 5'd2, 14'h0);
    check("R7 no busy soft clear", busy_n, 1);
    clr_n_pin = 1'b0;
    saw = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (!busy_n) saw = 1'b1;
    end
    check("R7 no busy pin clear", saw, 0);
    clr_n_pin = 1'b1;
    repeat (4) @(negedge clk);
    expect_rd(2'b11, 0, 14'h0321, "R7 data0 kept");
    expect_rd(2'b11, 4, 14'h0200, "R7 data4 kept");
    expect_rd(2'b00, 0, 14'h0321, "R7 clrcode kept");
    drain();
    send(2'b00, 5'd9, 14'h0);
    check("R6 soft pu", pd_active, 0);
    @(negedge clk);
    pd_pin = 1'b1;
    @(negedge clk);
    check("R6 pin pd", pd_active, 1);
    send(2'b00, 5'd9, 14'h0);
    check("R6 pu cannot override pin", pd_active, 1);
    send(2'b11, 5'd6, 14'h0066);
    expect_rd(2'b11, 6, 14'h0321, "R7 pin pd rejects write");
    drain();
    pd_pin = 1'b0;
    @(negedge clk);
    check("R6 pin released", pd_active, 0);
    send(2'b11, 5'd6, 14'h0066);
    expect_rd(2'b11, 6, 14'h0066, "R1 write after power-up");
    drain();

    // R8 soft reset, accepted while powered down
    send(2'b00, 5'd8, 14'h0);
    send(2'b00, 5'd15, 14'h1FFF);
    check("R8 soft pd cleared", pd_active, 0);
    count_busy(n);
    check("R8 busy length", n, RST_CYC);
    expect_rd(2'b11, 0, 14'h0, "R8 data0");
    expect_rd(2'b11, 6, 14'h0, "R8 data6");
    expect_rd(2'b01, 3, 14'h3FFF, "R8 gain3");
    expect_rd(2'b10, 3, 14'h0, "R8 offs3");
    expect_rd(2'b00, 0, 14'h0, "R8 clrcode");
    drain();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule